// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Descriptor Walker

This engine follows a chain of descriptors kept in memory and replays each descriptor's buffer as 32-bit beats on a streaming data output. A packet may span several descriptors. A start flag in a descriptor marks the first piece of a packet and an end flag marks the last piece. When a packet begins, the engine first sends the descriptor's application words on a separate control stream. When a packet ends, the data stream marks the final beat and the engine gives one completion pulse.

All memory traffic uses one request/response port with one request outstanding at a time. Reads return one 32-bit word a cycle or more after the request is accepted, and writes need no response. The register block gives the current and tail descriptor addresses with a start strobe, plus a run level. It gets back the current pointer, a busy level and single-cycle halted, idle and completion events.

A walk ends in one of two ways. It halts on a descriptor whose status already shows complete, and that descriptor is left untouched. Otherwise it goes idle after the descriptor at the tail address has been processed.

Top module: `sgd_mm2s_engine`

## Requirements
- R1: A start strobe is taken only when run is high and the engine is not busy. A strobe with run low leaves busy low and issues no memory request.
- R2: Descriptors are little-endian, laid out as next pointer at byte 0x00, buffer address at 0x08, control word at 0x18, status word at 0x1C and application words from 0x20. Control bits 22:0 hold the byte length, bit 26 the end flag and bit 27 the start flag. Buffers are word aligned.
- R3: A fetched descriptor whose status bit 31 is set produces one halted pulse and then busy low. It produces no stream beat and no write, and the current pointer stays at that descriptor.
- R4: A descriptor with the start flag sends its five application words, in address order, on the control stream before any data beat. The control last flag is set on the fifth word only.
- R5: Buffer bytes leave as ceil(length/4) beats, with byte 0 in data bits 7:0. Keep is 4'hF on every beat except the final one, whose keep has the low (length mod 4) bits set, or all four bits when that value is 0.
- R6: The data last flag is set only on the final beat of a descriptor with the end flag. Each such descriptor gives exactly one completion pulse, and that pulse comes with its status write.
- R7: After all of a descriptor's beats are accepted, the engine writes (length | 1<<31) to the descriptor address plus 0x1C.
- R8: After the status write, the current pointer takes the next pointer. If the processed descriptor was the tail, one idle pulse follows and busy drops. Otherwise the next descriptor is fetched.
- R9: While a stream or memory request is valid but not accepted, its valid stays high and its payload stays stable. Output stalls never lose or reorder beats.
- R10: Halted and idle pulses never occur in the same cycle.
- R11: After reset, busy, all valids and all event pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run enable level |
| start_i | input | 1 | Start strobe, one cycle |
| cur_ptr_i | input | AW | First descriptor address, sampled on start |
| tail_ptr_i | input | AW | Tail descriptor address, sampled on start |
| cur_ptr_o | output | AW | Current descriptor pointer |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Packet completion pulse |
| halted_o | output | 1 | Halt event pulse |
| idle_o | output | 1 | Idle event pulse |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | AW | Byte address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Read response data |
| dat_tvalid_o | output | 1 | Data stream valid |
| dat_tready_i | input | 1 | Data stream ready |
| dat_tdata_o | output | 32 | Data stream beat |
| dat_tkeep_o | output | 4 | Byte keep |
| dat_tlast_o | output | 1 | End of packet |
| ctl_tvalid_o | output | 1 | Control stream valid |
| ctl_tready_i | input | 1 | Control stream ready |
| ctl_tdata_o | output | 32 | Application word |
| ctl_tlast_o | output | 1 | Last application word |

## Verification
The bench targets packets split across several descriptors. An engine that framed each descriptor as its own packet would put out extra last flags and extra completion pulses. Lengths of every residue mod 4 check the final-beat keep, which a wrong rounding would truncate or pad. Chains with an already-complete descriptor in the middle check that the walk halts with the pointer on that descriptor and writes nothing to it. Random ready on all three ports checks that stalls neither drop nor repeat beats, and a start strobe with run low must leave memory untouched.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int SGD_LEN_W    = 23;
  localparam int SGD_EOF_BIT  = 26;
  localparam int SGD_SOF_BIT  = 27;
  localparam int SGD_DONE_BIT = 31;
  localparam int SGD_CNT_W    = SGD_LEN_W - 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DREQ, ST_DRSP, ST_AREQ, ST_ARSP,
    ST_BREQ, ST_BRSP, ST_WB, ST_ADV
  } sgd_state_e;

  // byte offset of the n-th fetched descriptor word (skips reserved bytes)
  function automatic logic [5:0] desc_word_off(input logic [2:0] n);
    return (n < 3'd4) ? {1'b0, n, 2'b00} : ({1'b0, n, 2'b00} + 6'd8);
  endfunction

  function automatic logic [SGD_CNT_W-1:0] beat_total(input logic [SGD_LEN_W-1:0] len);
    logic [SGD_LEN_W:0] sum;
    sum = {1'b0, len} + 3;
    return sum[SGD_LEN_W:2];
  endfunction

  function automatic logic [3:0] tail_keep(input logic [1:0] rem);
    return (rem == 2'd0) ? 4'hF : ((4'h1 << rem) - 4'h1);
  endfunction
endpackage

// File: rtl/sgd_out_slot.sv
module sgd_out_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sgd_beat_plan.sv
module sgd_beat_plan
  import sgd_pkg::*;
(
  input  logic [SGD_LEN_W-1:0] len_i,
  input  logic [SGD_CNT_W-1:0] beat_i,
  output logic                 empty_o,
  output logic                 last_o,
  output logic [3:0]           keep_o
);
  logic [SGD_CNT_W-1:0] total;
  assign total   = beat_total(len_i);
  assign empty_o = (total == '0);
  assign last_o  = (beat_i == total - 1'b1);
  assign keep_o  = last_o ? tail_keep(len_i[1:0]) : 4'hF;
endmodule

// File: rtl/sgd_mm2s_engine.sv
module sgd_mm2s_engine
  import sgd_pkg::*;
#(
  parameter int AW        = 64,
  parameter int APP_WORDS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          start_i,
  input  logic [AW-1:0] cur_ptr_i,
  input  logic [AW-1:0] tail_ptr_i,
  output logic [AW-1:0] cur_ptr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          halted_o,
  output logic          idle_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [31:0]   mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [31:0]   mem_rsp_data_i,
  output logic          dat_tvalid_o,
  input  logic          dat_tready_i,
  output logic [31:0]   dat_tdata_o,
  output logic [3:0]    dat_tkeep_o,
  output logic          dat_tlast_o,
  output logic          ctl_tvalid_o,
  input  logic          ctl_tready_i,
  output logic [31:0]   ctl_tdata_o,
  output logic          ctl_tlast_o
);
  localparam int APP_IW    = $clog2(APP_WORDS + 1);
  localparam logic [AW-1:0] OFF_STATUS = AW'(28);
  localparam logic [AW-1:0] OFF_APP    = AW'(32);

  sgd_state_e           state;
  logic [2:0]           dw_idx;
  logic [APP_IW-1:0]    app_idx;
  logic [SGD_CNT_W-1:0] beat_idx;
  logic [AW-1:0]        desc_q, tail_q, nxt_q, buf_q;
  logic [SGD_LEN_W-1:0] len_q;
  logic                 sof_q, eof_q;

  // named internal events
  logic req_hs, rsp_status, app_last, beat_empty, beat_last, at_tail;
  logic [3:0] beat_keep;
  logic ctl_load, dat_load;

  sgd_beat_plan plan_i (
    .len_i(len_q), .beat_i(beat_idx),
    .empty_o(beat_empty), .last_o(beat_last), .keep_o(beat_keep)
  );

  assign req_hs     = mem_req_valid_o && mem_req_ready_i;
  assign rsp_status = (state == ST_DRSP) && mem_rsp_valid_i && (dw_idx == 3'd5);
  assign app_last   = (app_idx == APP_IW'(APP_WORDS - 1));
  assign at_tail    = (desc_q == tail_q);
  assign ctl_load   = (state == ST_ARSP) && mem_rsp_valid_i;
  assign dat_load   = (state == ST_BRSP) && mem_rsp_valid_i;

  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_addr_o  = '0;
    unique case (state)
      ST_DREQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = desc_q + AW'(desc_word_off(dw_idx));
      end
      ST_AREQ: begin
        mem_req_valid_o = !ctl_tvalid_o;
        mem_req_addr_o  = desc_q + OFF_APP + (AW'(app_idx) << 2);
      end
      ST_BREQ: begin
        mem_req_valid_o = !dat_tvalid_o && !ctl_tvalid_o;
        mem_req_addr_o  = buf_q + (AW'(beat_idx) << 2);
      end
      ST_WB: begin
        mem_req_valid_o = !dat_tvalid_o;
        mem_req_addr_o  = desc_q + OFF_STATUS;
      end
      default: ;
    endcase
  end

  assign mem_req_we_o    = (state == ST_WB);
  assign mem_req_wdata_o = {1'b1, {(31 - SGD_LEN_W){1'b0}}, len_q};
  assign busy_o    = (state != ST_IDLE);
  assign cur_ptr_o = desc_q;
  assign done_o    = (state == ST_WB) && req_hs && eof_q;
  assign halted_o  = rsp_status && mem_rsp_data_i[SGD_DONE_BIT];
  assign idle_o    = (state == ST_ADV) && at_tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dw_idx   <= '0;
      app_idx  <= '0;
      beat_idx <= '0;
      desc_q   <= '0;
      tail_q   <= '0;
      nxt_q    <= '0;
      buf_q    <= '0;
      len_q    <= '0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i && run_i) begin
          desc_q <= cur_ptr_i;
          tail_q <= tail_ptr_i;
          dw_idx <= '0;
          state  <= ST_DREQ;
        end
        ST_DREQ: if (req_hs) state <= ST_DRSP;
        ST_DRSP: if (mem_rsp_valid_i) begin
          unique case (dw_idx)
            3'd0: nxt_q[31:0]     <= mem_rsp_data_i;
            3'd1: nxt_q[AW-1:32]  <= mem_rsp_data_i[AW-33:0];
            3'd2: buf_q[31:0]     <= mem_rsp_data_i;
            3'd3: buf_q[AW-1:32]  <= mem_rsp_data_i[AW-33:0];
            3'd4: begin
              len_q <= mem_rsp_data_i[SGD_LEN_W-1:0];
              sof_q <= mem_rsp_data_i[SGD_SOF_BIT];
              eof_q <= mem_rsp_data_i[SGD_EOF_BIT];
            end
            default: ;
          endcase
          if (dw_idx != 3'd5) begin
            dw_idx <= dw_idx + 3'd1;
            state  <= ST_DREQ;
          end else if (mem_rsp_data_i[SGD_DONE_BIT]) begin
            state <= ST_IDLE;
          end else if (sof_q) begin
            app_idx <= '0;
            state   <= ST_AREQ;
          end else begin
            beat_idx <= '0;
            state    <= beat_empty ? ST_WB : ST_BREQ;
          end
        end
        ST_AREQ: if (req_hs) state <= ST_ARSP;
        ST_ARSP: if (mem_rsp_valid_i) begin
          if (app_last) begin
            beat_idx <= '0;
            state    <= beat_empty ? ST_WB : ST_BREQ;
          end else begin
            app_idx <= app_idx + 1'b1;
            state   <= ST_AREQ;
          end
        end
        ST_BREQ: if (req_hs) state <= ST_BRSP;
        ST_BRSP: if (mem_rsp_valid_i) begin
          if (beat_last) state <= ST_WB;
          else begin
            beat_idx <= beat_idx + 1'b1;
            state    <= ST_BREQ;
          end
        end
        ST_WB: if (req_hs) state <= ST_ADV;
        ST_ADV: begin
          desc_q <= nxt_q;
          dw_idx <= '0;
          state  <= at_tail ? ST_IDLE : ST_DREQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  sgd_out_slot #(.W(33)) ctl_slot_i (
    .clk(clk), .rst_n(rst_n), .load_i(ctl_load),
    .data_i({app_last, mem_rsp_data_i}), .ready_i(ctl_tready_i),
    .valid_o(ctl_tvalid_o), .data_o({ctl_tlast_o, ctl_tdata_o})
  );

  sgd_out_slot #(.W(37)) dat_slot_i (
    .clk(clk), .rst_n(rst_n), .load_i(dat_load),
    .data_i({beat_last && eof_q, beat_keep, mem_rsp_data_i}), .ready_i(dat_tready_i),
    .valid_o(dat_tvalid_o), .data_o({dat_tlast_o, dat_tkeep_o, dat_tdata_o})
  );
endmodule

// File: rtl/sgd_mm2s_chk.sv
module sgd_mm2s_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_i,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          halted_o,
  input logic          idle_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic          mem_req_we_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic [31:0]   mem_req_wdata_o,
  input logic          dat_tvalid_o,
  input logic          dat_tready_i,
  input logic [31:0]   dat_tdata_o,
  input logic [3:0]    dat_tkeep_o,
  input logic          dat_tlast_o,
  input logic          ctl_tvalid_o,
  input logic          ctl_tready_i,
  input logic [31:0]   ctl_tdata_o,
  input logic          ctl_tlast_o
);
  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !run_i) |=> !busy_o);
  // R11
  quiet_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_valid_o && !done_o && !halted_o && !idle_o));
  // R3
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> !busy_o);
  // R4
  app_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_tvalid_o |-> !ctl_tvalid_o);
  // R5
  keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_tvalid_o |-> (dat_tkeep_o inside {4'h1, 4'h3, 4'h7, 4'hF}));
  // R6
  done_with_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mem_req_valid_o && mem_req_ready_i && mem_req_we_o));
  // R7
  wb_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_we_o) |-> (!dat_tvalid_o && mem_req_wdata_o[31]));
  // R8
  idle_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |=> !busy_o);
  // R9
  dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_tvalid_o && !dat_tready_i) |=>
      (dat_tvalid_o && $stable(dat_tdata_o) && $stable(dat_tkeep_o) && $stable(dat_tlast_o)));
  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_tvalid_o && !ctl_tready_i) |=>
      (ctl_tvalid_o && $stable(ctl_tdata_o) && $stable(ctl_tlast_o)));
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)));
  // R10
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted_o && idle_o));
endmodule

bind sgd_mm2s_engine sgd_mm2s_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .halted_o(halted_o), .idle_o(idle_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o),
  .dat_tvalid_o(dat_tvalid_o), .dat_tready_i(dat_tready_i), .dat_tdata_o(dat_tdata_o),
  .dat_tkeep_o(dat_tkeep_o), .dat_tlast_o(dat_tlast_o),
  .ctl_tvalid_o(ctl_tvalid_o), .ctl_tready_i(ctl_tready_i), .ctl_tdata_o(ctl_tdata_o),
  .ctl_tlast_o(ctl_tlast_o)
);

// File: tb/sgd_mm2s_engine_tb.sv
module sgd_mm2s_engine_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, run = 1'b0, start = 1'b0;
  logic [63:0] cur_in = '0, tail_in = '0, cur_out;
  logic        busy, done, halted, idle;
  logic        req_v, req_rdy = 1'b0, req_we, rsp_v = 1'b0;
  logic [63:0] req_addr;
  logic [31:0] req_wd, rsp_d = '0;
  logic        dv, drdy = 1'b0, dlast, cv, crdy = 1'b0, clast;
  logic [31:0] dd, cd;
  logic [3:0]  dk;

  sgd_mm2s_engine dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .start_i(start),
    .cur_ptr_i(cur_in), .tail_ptr_i(tail_in), .cur_ptr_o(cur_out),
    .busy_o(busy), .done_o(done), .halted_o(halted), .idle_o(idle),
    .mem_req_valid_o(req_v), .mem_req_ready_i(req_rdy), .mem_req_we_o(req_we),
    .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wd),
    .mem_rsp_valid_i(rsp_v), .mem_rsp_data_i(rsp_d),
    .dat_tvalid_o(dv), .dat_tready_i(drdy), .dat_tdata_o(dd), .dat_tkeep_o(dk),
    .dat_tlast_o(dlast),
    .ctl_tvalid_o(cv), .ctl_tready_i(crdy), .ctl_tdata_o(cd), .ctl_tlast_o(clast)
  );

  logic [31:0] mem [0:1023];
  logic [36:0] got_dat[$], exp_dat[$];
  logic [32:0] got_ctl[$], exp_ctl[$];
  logic [63:0] got_wr[$],  exp_wr[$];
  int n_done, n_halt, n_idle, n_req;
  int exp_done, exp_halt, exp_idle;
  logic [63:0] exp_cur;
  int checks = 0, failures = 0;
  int stall_pct = 25;

  // memory, sinks and event monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_v <= 1'b0; req_rdy <= 1'b0; drdy <= 1'b0; crdy <= 1'b0;
    end else begin
      rsp_v <= 1'b0;
      if (req_v && req_rdy) begin
        n_req++;
        if (req_we) got_wr.push_back({req_addr[31:0], req_wd});
        else begin
          rsp_v <= 1'b1;
          rsp_d <= mem[req_addr[11:2]];
        end
      end
      if (dv && drdy) got_dat.push_back({dlast, dk, dd});
      if (cv && crdy) got_ctl.push_back({clast, cd});
      if (done) n_done++;
      if (halted) n_halt++;
      if (idle) n_idle++;
      req_rdy <= ($urandom % 100) >= stall_pct;
      drdy    <= ($urandom % 100) >= stall_pct;
      crdy    <= ($urandom % 100) >= stall_pct;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int da(input int k); return 32'h40 * k; endfunction
  function automatic int ba(input int k); return 32'h400 + 32'h40 * k; endfunction

  task automatic mk_desc(input int k, input int nxt, input int len, input bit sof,
                         input bit eof, input bit cmpl);
    int w = da(k) / 4;
    mem[w] = nxt; mem[w+1] = 0; mem[w+2] = ba(k); mem[w+3] = 0;
    mem[w+4] = $urandom; mem[w+5] = $urandom;
    mem[w+6] = (len & 32'h7FFFFF) | (32'(eof) << 26) | (32'(sof) << 27);
    mem[w+7] = cmpl ? 32'h8000_0000 : 32'h0;
    for (int a = 0; a < 5; a++) mem[w+8+a] = $urandom;
    for (int b = 0; b < 16; b++) mem[ba(k)/4 + b] = $urandom;
  endtask

  // independent walk over the memory image
  task automatic predict(input int cur, input int tail);
    int p = cur;
    exp_dat.delete(); exp_ctl.delete(); exp_wr.delete();
    exp_done = 0; exp_halt = 0; exp_idle = 0;
    for (int it = 0; it < 64; it++) begin
      int w = p / 4;
      int ctrl = mem[w+6];
      int len = ctrl & 32'h7FFFFF;
      int nb = (len + 3) / 4;
      if (mem[w+7][31]) begin exp_halt = 1; exp_cur = p; return; end
      if (ctrl[27]) for (int a = 0; a < 5; a++) exp_ctl.push_back({a == 4, mem[w+8+a]});
      for (int i = 0; i < nb; i++) begin
        int bytes = (len - 4*i > 4) ? 4 : len - 4*i;
        logic [3:0] kp = 4'((1 << bytes) - 1);
        exp_dat.push_back({(i == nb-1) && ctrl[26], kp, mem[mem[w+2]/4 + i]});
      end
      exp_wr.push_back({32'(p + 28), 32'(len) | 32'h8000_0000});
      if (ctrl[26]) exp_done++;
      if (p == tail) begin exp_idle = 1; exp_cur = mem[w]; return; end
      p = mem[w];
    end
  endtask

  task automatic run_walk(input int cur, input int tail, input string tag);
    predict(cur, tail);
    got_dat.delete(); got_ctl.delete(); got_wr.delete();
    n_done = 0; n_halt = 0; n_idle = 0;
    @(negedge clk);
    run = 1'b1; start = 1'b1; cur_in = 64'(cur); tail_in = 64'(tail);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 8000 && busy; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    // R3 R8 R10: how the walk ended
    chk(n_halt == exp_halt && n_idle == exp_idle, {tag, " R3/R8 end event"},
        {n_halt, n_idle}, {exp_halt, exp_idle});
    chk(cur_out == exp_cur, {tag, " R8 current pointer"}, cur_out, exp_cur);
    // R6 completions
    chk(n_done == exp_done, {tag, " R6 completion pulses"}, n_done, exp_done);
    // R5 R6 R9 data beats
    chk(got_dat.size() == exp_dat.size(), {tag, " R5 beat count"}, got_dat.size(), exp_dat.size());
    for (int i = 0; i < got_dat.size() && i < exp_dat.size(); i++)
      if (got_dat[i] != exp_dat[i]) begin
        chk(0, {tag, " R5 data/keep/last beat"}, got_dat[i], exp_dat[i]); break;
      end
    // R4 application words
    chk(got_ctl.size() == exp_ctl.size(), {tag, " R4 app word count"}, got_ctl.size(), exp_ctl.size());
    for (int i = 0; i < got_ctl.size() && i < exp_ctl.size(); i++)
      if (got_ctl[i] != exp_ctl[i]) begin
        chk(0, {tag, " R4 app word"}, got_ctl[i], exp_ctl[i]); break;
      end
    // R7 status write-back, R2 layout
    chk(got_wr.size() == exp_wr.size(), {tag, " R7 write count"}, got_wr.size(), exp_wr.size());
    for (int i = 0; i < got_wr.size() && i < exp_wr.size(); i++)
      if (got_wr[i] != exp_wr[i]) begin
        chk(0, {tag, " R7/R2 write addr/data"}, got_wr[i], exp_wr[i]); break;
      end
    foreach (got_wr[i]) mem[got_wr[i][43:34]] = got_wr[i][31:0];
  endtask

  task automatic tests();
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!busy && !req_v && !dv && !cv, "R11 reset valids", {busy, req_v, dv, cv}, 0);
    chk(!done && !halted && !idle, "R11 reset events", {done, halted, idle}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 start without run
    mk_desc(0, da(1), 8, 1, 1, 0);
    n_req = 0;
    run = 1'b0; start = 1'b1; cur_in = 0; tail_in = 0;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy && n_req == 0, "R1 start ignored with run low", n_req, 0);
    // single packet, one descriptor, length 10
    mk_desc(0, da(1), 10, 1, 1, 0);
    run_walk(da(0), da(0), "single");
    // packet over three descriptors, residues 1,0,3
    mk_desc(1, da(2), 5, 1, 0, 0);
    mk_desc(2, da(3), 8, 0, 0, 0);
    mk_desc(3, da(4), 7, 0, 1, 0);
    run_walk(da(1), da(3), "spanning");
    // halt on a descriptor already complete
    mk_desc(4, da(5), 12, 1, 1, 0);
    mk_desc(5, da(6), 6, 1, 1, 1);
    run_walk(da(4), da(6), "halt");
    // full stall-free run and heavy stall run
    stall_pct = 0;
    mk_desc(6, da(7), 16, 1, 1, 0);
    run_walk(da(6), da(6), "nostall");
    stall_pct = 70;
    mk_desc(7, da(8), 2, 1, 0, 0);
    mk_desc(8, da(9), 3, 0, 1, 0);
    run_walk(da(7), da(8), "heavystall");
    // random chains
    for (int r = 0; r < 10; r++) begin
      int n = 1 + ($urandom % 6);
      int hpos = (($urandom % 3) == 0) ? int'($urandom % n) : -1;
      bit open = 0;
      stall_pct = $urandom % 60;
      for (int k = 0; k < n; k++) begin
        bit s = !open || (($urandom % 4) == 0);
        bit e = (k == n-1) || (($urandom % 2) == 0);
        mk_desc(k, da(k+1), 1 + ($urandom % 40), s, e, k == hpos);
        open = !e;
      end
      run_walk(da(0), da(n-1), $sformatf("random%0d", r));
    end
  endtask

  initial begin
    bit wd = 0;
    fork
      tests();
      begin repeat (150000) @(posedge clk); wd = 1; end
    join_any
    disable fork;
    if (wd) begin
      failures++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule